// File: doc/BRIEF.md
# DMA Channel Lifecycle and Abort Controller

This block runs a small set of DMA channels through their lifecycle. A channel is started with a programmed length, paused and resumed, and finished either by normal completion or by a forced abort. A stub engine inside each channel issues one read per cycle while the channel is running. It counts the reads still waiting for their write acknowledge and stops issuing when a per-channel cap of outstanding transfers is reached. An external write master returns one acknowledge pulse per transfer.

Software uses a word-wide register port with a registered read path. An abort request clears the channel's remaining count and busy flag at once. The abort bit then stays readable as high until every transfer already in flight has been acknowledged. An abort is never reported as a completion. A normal completion latches a per-channel status bit. Two interrupt lines each OR together the status bits that their own mask enables.

Register offsets (4-bit address): 0 enable mask (rw); 1 start (write 1 per channel) / busy mask (read); 2 abort request (write 1) / abort pending (read); 3 completion status (read, write 1 to clear); 4 mask for `irq0`; 5 mask for `irq1`; 8+n length of channel n (write) / live remaining count of channel n (read).

Top module: `dmax_abort_ctrl`

## Requirements
- R1: After reset the enable, busy, abort, status and both mask registers read 0, and `irq0` and `irq1` are low.
- R2: Writing 1 to bit n of the start register at offset 1 loads channel n's remaining count from its length register and sets busy bit n. While the channel is enabled, one read is issued per cycle, shown as a one-cycle pulse on `rd_req[n]`, and each read lowers the remaining count (read at offset 8+n) by one.
- R3: Each issued read is outstanding until its `wr_ack` pulse arrives. No more than MAX_OUT reads are outstanding per channel, and issuing stalls at that cap.
- R4: When the remaining count is 0 and no read is outstanding, the channel clears its busy bit and sets its status bit at offset 3.
- R5: Clearing an enable bit at offset 0 stops new reads without changing the remaining count or busy bit. Setting it again resumes the transfer, which runs to completion.
- R6: Writing 1 to bit n of the abort register at offset 2 sets channel n's remaining count to 0 and clears its busy bit on the same edge.
- R7: An abort bit reads 1 from the request until the first edge at which the channel has no outstanding reads. It clears on that edge, which is the edge right after the request if nothing was outstanding. Acknowledges for reads issued before the abort are still accepted.
- R8: An abort never sets the channel's status bit and never raises an interrupt.
- R9: Writing 0 to an abort bit has no effect, and software cannot clear a pending abort bit.
- R10: A start request for a channel whose abort bit reads 1 is ignored. The channel stays idle, its count stays 0 and it issues no read.
- R11: Writing 1 to a status bit clears it, and `irq0`/`irq1` drop one cycle later.
- R12: `irq0` is the registered OR of the status bits masked by offset 4, and `irq1` is the same using offset 5. Each follows the status one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | ADDR_W | Register write offset |
| reg_wr_data | input | DATA_W | Register write data |
| reg_rd_en | input | 1 | Register read strobe |
| reg_rd_addr | input | ADDR_W | Register read offset |
| reg_rd_data | output | DATA_W | Read data, valid the cycle after the strobe |
| rd_req | output | NCH | Per-channel read-issued pulse |
| wr_ack | input | NCH | Per-channel write acknowledge, one per outstanding read |
| irq0 | output | 1 | First completion interrupt |
| irq1 | output | 1 | Second completion interrupt |

## Verification
A wrong outstanding-transfer count is visible at the ports. If the count is too low, the abort bit reads 0 while acknowledges are still due. If the count is too high, the abort bit stays set after the last acknowledge, and at the cap the number of `rd_req` pulses comes out wrong within a few cycles. A status bit wrongly set by an abort shows on the status read and on the enabled interrupt line one cycle later. A lost pause or a lost block on restart shows as a changed remaining count or a stray `rd_req` pulse.

// File: rtl/dmax_pkg.sv
package dmax_pkg;
  // register selects in the low three address bits (top address bit clear)
  localparam logic [2:0] RA_ENA   = 3'd0;
  localparam logic [2:0] RA_GO    = 3'd1;
  localparam logic [2:0] RA_ABORT = 3'd2;
  localparam logic [2:0] RA_STAT  = 3'd3;
  localparam logic [2:0] RA_MASK0 = 3'd4;
  localparam logic [2:0] RA_MASK1 = 3'd5;
endpackage

// File: rtl/dmax_regs.sv
module dmax_regs #(
  parameter int NCH    = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          rd_addr,
  input  logic [NCH-1:0]             busy_i,
  input  logic [NCH-1:0]             abort_pend_i,
  input  logic [NCH-1:0]             status_i,
  input  logic [NCH-1:0][CNT_W-1:0]  remain_i,
  output logic [NCH-1:0]             ena_q,
  output logic [NCH-1:0]             mask0_q,
  output logic [NCH-1:0]             mask1_q,
  output logic [NCH-1:0][CNT_W-1:0]  len_q,
  output logic [NCH-1:0]             go_p,
  output logic [NCH-1:0]             abort_p,
  output logic [NCH-1:0]             clr_p,
  output logic [DATA_W-1:0]          rd_data
);
  import dmax_pkg::*;
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic wr_ctl;
  assign wr_ctl  = wr_en && !wr_addr[ADDR_W-1];
  assign go_p    = (wr_ctl && wr_addr[2:0] == RA_GO)    ? wr_data[NCH-1:0] : '0;
  assign abort_p = (wr_ctl && wr_addr[2:0] == RA_ABORT) ? wr_data[NCH-1:0] : '0;
  assign clr_p   = (wr_ctl && wr_addr[2:0] == RA_STAT)  ? wr_data[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ena_q   <= '0;
      mask0_q <= '0;
      mask1_q <= '0;
      len_q   <= '0;
    end else if (wr_en) begin
      if (wr_addr[ADDR_W-1]) begin
        for (int c = 0; c < NCH; c++)
          if (wr_addr[IDX_W-1:0] == IDX_W'(c)) len_q[c] <= wr_data[CNT_W-1:0];
      end else begin
        case (wr_addr[2:0])
          RA_ENA:   ena_q   <= wr_data[NCH-1:0];
          RA_MASK0: mask0_q <= wr_data[NCH-1:0];
          RA_MASK1: mask1_q <= wr_data[NCH-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= '0;
      if (rd_addr[ADDR_W-1]) begin
        for (int c = 0; c < NCH; c++)
          if (rd_addr[IDX_W-1:0] == IDX_W'(c)) rd_data <= DATA_W'(remain_i[c]);
      end else begin
        case (rd_addr[2:0])
          RA_ENA:   rd_data <= DATA_W'(ena_q);
          RA_GO:    rd_data <= DATA_W'(busy_i);
          RA_ABORT: rd_data <= DATA_W'(abort_pend_i);
          RA_STAT:  rd_data <= DATA_W'(status_i);
          RA_MASK0: rd_data <= DATA_W'(mask0_q);
          RA_MASK1: rd_data <= DATA_W'(mask1_q);
          default:  rd_data <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/dmax_chan.sv
module dmax_chan #(
  parameter int CNT_W   = 16,
  parameter int MAX_OUT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             go_i,
  input  logic             abort_i,
  input  logic             wr_ack_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             busy_q,
  output logic             abort_pend_q,
  output logic [CNT_W-1:0] remain_q,
  output logic             rd_req_q,
  output logic             done_o
);
  localparam int OUT_W = $clog2(MAX_OUT + 1);

  logic [OUT_W-1:0] inflight_q;
  logic can_issue, ack;

  assign can_issue = busy_q && en_i && !abort_i && (remain_q != '0) &&
                     (inflight_q < OUT_W'(MAX_OUT));
  assign ack       = wr_ack_i && (inflight_q != '0);
  assign done_o    = busy_q && !abort_i && (remain_q == '0) && (inflight_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q       <= 1'b0;
      abort_pend_q <= 1'b0;
      remain_q     <= '0;
      rd_req_q     <= 1'b0;
      inflight_q   <= '0;
    end else begin
      rd_req_q   <= can_issue;
      inflight_q <= inflight_q + OUT_W'(can_issue) - OUT_W'(ack);
      if (abort_i)                              abort_pend_q <= 1'b1;
      else if (abort_pend_q && inflight_q == '0) abort_pend_q <= 1'b0;
      if (abort_i) begin
        busy_q   <= 1'b0;
        remain_q <= '0;
      end else if (go_i && !busy_q && !abort_pend_q) begin
        busy_q   <= 1'b1;
        remain_q <= len_i;
      end else if (can_issue) begin
        remain_q <= remain_q - 1'b1;
      end else if (done_o) begin
        busy_q <= 1'b0;
      end
    end
  end

  AST_OUT_CAP: assert property (@(posedge clk) disable iff (rst)
    inflight_q <= OUT_W'(MAX_OUT)); // R3
  AST_ABORT_KILL: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> (!busy_q && remain_q == '0)); // R6
  AST_ABORT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (abort_pend_q && inflight_q != '0) |=> abort_pend_q); // R7
  AST_GO_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (go_i && abort_pend_q) |=> !busy_q); // R10
  AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !rd_req_q); // R5
endmodule

// File: rtl/dmax_irq.sv
module dmax_irq #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] done_i,
  input  logic [NCH-1:0] clr_i,
  input  logic [NCH-1:0] mask0_i,
  input  logic [NCH-1:0] mask1_i,
  output logic [NCH-1:0] status_q,
  output logic           irq0_q,
  output logic           irq1_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      irq0_q   <= 1'b0;
      irq1_q   <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_i) | done_i;
      irq0_q   <= |(status_q & mask0_i);
      irq1_q   <= |(status_q & mask1_i);
    end
  end

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ((clr_i & ~done_i) != '0) |=> ((status_q & $past(clr_i & ~done_i)) == '0)); // R11
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (rst)
    (irq0_q || irq1_q) |-> $past(status_q != '0)); // R12
endmodule

// File: rtl/dmax_abort_ctrl.sv
module dmax_abort_ctrl #(
  parameter int NCH     = 4,
  parameter int CNT_W   = 16,
  parameter int MAX_OUT = 4,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_wr_addr,
  input  logic [DATA_W-1:0] reg_wr_data,
  input  logic              reg_rd_en,
  input  logic [ADDR_W-1:0] reg_rd_addr,
  output logic [DATA_W-1:0] reg_rd_data,
  output logic [NCH-1:0]    rd_req,
  input  logic [NCH-1:0]    wr_ack,
  output logic              irq0,
  output logic              irq1
);
  logic [NCH-1:0]            ena, mask0, mask1, go_p, abort_p, clr_p;
  logic [NCH-1:0]            busy, abort_pend, status, done;
  logic [NCH-1:0][CNT_W-1:0] len, remain;

  dmax_regs #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst(rst),
    .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
    .rd_en(reg_rd_en), .rd_addr(reg_rd_addr),
    .busy_i(busy), .abort_pend_i(abort_pend), .status_i(status), .remain_i(remain),
    .ena_q(ena), .mask0_q(mask0), .mask1_q(mask1), .len_q(len),
    .go_p(go_p), .abort_p(abort_p), .clr_p(clr_p), .rd_data(reg_rd_data)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    dmax_chan #(.CNT_W(CNT_W), .MAX_OUT(MAX_OUT)) chan_i (
      .clk(clk), .rst(rst),
      .en_i(ena[c]), .go_i(go_p[c]), .abort_i(abort_p[c]), .wr_ack_i(wr_ack[c]),
      .len_i(len[c]),
      .busy_q(busy[c]), .abort_pend_q(abort_pend[c]), .remain_q(remain[c]),
      .rd_req_q(rd_req[c]), .done_o(done[c])
    );

    AST_ABORT_NO_STATUS: assert property (@(posedge clk) disable iff (rst)
      (abort_p[c] && !status[c]) |=> !status[c]); // R8
  end

  dmax_irq #(.NCH(NCH)) irq_i (
    .clk(clk), .rst(rst),
    .done_i(done), .clr_i(clr_p), .mask0_i(mask0), .mask1_i(mask1),
    .status_q(status), .irq0_q(irq0), .irq1_q(irq1)
  );
endmodule

// File: tb/dmax_abort_ctrl_tb_top.sv
module dmax_abort_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int AW  = 4;
  localparam int DW  = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr_en = 1'b0;
  logic [AW-1:0] reg_wr_addr = '0;
  logic [DW-1:0] reg_wr_data = '0;
  logic          reg_rd_en = 1'b0;
  logic [AW-1:0] reg_rd_addr = '0;
  logic [DW-1:0] reg_rd_data;
  logic [NCH-1:0] rd_req;
  logic [NCH-1:0] wr_ack = '0;
  logic          irq0, irq1;

  int n_cmp = 0;
  int n_bad = 0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  bit  auto_ack[NCH];
  int  man_ack[NCH];
  int  pend[NCH];
  int  rd_cnt[NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  dmax_abort_ctrl dut_i (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_en(reg_rd_en), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .rd_req(rd_req), .wr_ack(wr_ack), .irq0(irq0), .irq1(irq1)
  );

  // write-master model: counts issued reads and returns acknowledges
  initial begin
    for (int c = 0; c < NCH; c++) begin
      auto_ack[c] = 1'b0; man_ack[c] = 0; pend[c] = 0; rd_cnt[c] = 0;
    end
    forever begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        if (rd_req[c]) begin pend[c]++; rd_cnt[c]++; end
        if (pend[c] > 0 && (auto_ack[c] || man_ack[c] > 0)) begin
          wr_ack[c] = 1'b1;
          pend[c]--;
          if (!auto_ack[c]) man_ack[c]--;
        end else begin
          wr_ack[c] = 1'b0;
        end
      end
    end
  end

  // monitor: compares registered read data against queued expectations
  initial begin
    forever begin
      @(posedge clk);
      if (reg_rd_en) begin
        #1;
        if (exp_q.size() != 0) begin
          logic [DW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          n_cmp++;
          if (reg_rd_data !== e) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", t, reg_rd_data, e);
          end
        end
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    reg_rd_en = 1'b1; reg_rd_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
  endtask

  task automatic chk(input int act, input int e, input string t);
    n_cmp++;
    if (act != e) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", t, act, e);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    rd(4'd0, 16'h0, "R1 enable");
    rd(4'd1, 16'h0, "R1 busy");
    rd(4'd2, 16'h0, "R1 abort");
    rd(4'd3, 16'h0, "R1 status");
    rd(4'd4, 16'h0, "R1 mask0");
    chk(int'(irq0), 0, "R1 irq0");
    chk(int'(irq1), 0, "R1 irq1");

    wr(4'd4, 16'h1);
    wr(4'd5, 16'h2);
    wr(4'd0, 16'h7);
    // R2 and R4: channel 0 runs three transfers to completion
    auto_ack[0] = 1'b1;
    wr(4'd8, 16'd3);
    wr(4'd1, 16'h1);
    tick(15);
    chk(rd_cnt[0], 3, "R2 reads issued ch0");
    rd(4'd1, 16'h0, "R4 busy cleared ch0");
    rd(4'd3, 16'h1, "R4 status set ch0");
    chk(int'(irq0), 1, "R12 irq0 from ch0");
    chk(int'(irq1), 0, "R12 irq1 masked");
    // R11 write one to clear
    wr(4'd3, 16'h1);
    tick(2);
    chk(int'(irq0), 0, "R11 irq0 dropped");
    rd(4'd3, 16'h0, "R11 status cleared");

    // R3 cap of outstanding reads on channel 1
    wr(4'd9, 16'd10);
    wr(4'd1, 16'h2);
    tick(10);
    chk(rd_cnt[1], 4, "R3 reads stall at cap");
    rd(4'd9, 16'd6, "R2 remaining ch1");
    rd(4'd1, 16'h2, "R2 busy ch1");
    // R6 and R7: abort with four reads outstanding
    wr(4'd2, 16'h2);
    rd(4'd2, 16'h2, "R7 abort held");
    rd(4'd1, 16'h0, "R6 busy cleared");
    rd(4'd9, 16'h0, "R6 count cleared");
    // R10 restart ignored while abort pending
    wr(4'd1, 16'h2);
    tick(2);
    rd(4'd1, 16'h0, "R10 restart ignored busy");
    rd(4'd9, 16'h0, "R10 restart ignored count");
    chk(rd_cnt[1], 4, "R10 no new reads");
    // R9 zero write has no effect
    wr(4'd2, 16'h0);
    rd(4'd2, 16'h2, "R9 abort not cleared");
    man_ack[1] = 3;
    tick(6);
    rd(4'd2, 16'h2, "R7 abort held one outstanding");
    man_ack[1] = 1;
    tick(3);
    rd(4'd2, 16'h0, "R7 abort released after drain");
    rd(4'd3, 16'h0, "R8 no status from abort");
    chk(int'(irq1), 0, "R8 no irq1 from abort");

    // R5 pause and resume on channel 2
    auto_ack[2] = 1'b1;
    wr(4'd10, 16'd6);
    wr(4'd1, 16'h4);
    wr(4'd0, 16'h3);
    tick(2);
    rd(4'd10, 16'd5, "R5 count kept while paused");
    tick(10);
    rd(4'd10, 16'd5, "R5 count frozen");
    rd(4'd1, 16'h4, "R5 busy kept");
    chk(rd_cnt[2], 1, "R5 no reads while paused");
    wr(4'd0, 16'h7);
    tick(30);
    chk(rd_cnt[2], 6, "R5 resumed reads");
    rd(4'd1, 16'h0, "R5 completed");
    rd(4'd3, 16'h4, "R4 status ch2");
    chk(int'(irq1), 0, "R12 irq1 unmasked ch2");
    wr(4'd5, 16'h6);
    tick(2);
    chk(int'(irq1), 1, "R12 irq1 after mask");

    // R7 boundary: abort of an idle channel clears after one edge
    wr(4'd2, 16'h8);
    rd(4'd2, 16'h8, "R7 idle abort visible");
    rd(4'd2, 16'h0, "R7 idle abort cleared");
    rd(4'd3, 16'h4, "R8 idle abort status");
    tick(3);
    finish_run();
  end
endmodule